// File: doc/BRIEF.md
# Channel-Zero Message Extractor

This block watches timeslot 0 of a set of serial PCM input lines and hands the bytes that count as messages to a host processor. Once per frame it takes the channel-0 byte from every line. A byte counts as a message unless its two top bits read `01`. The host chooses which lines take part by writing a line mask. The mask is split into a 3-bit high part and a 5-bit low part. It is kept both as a working "expected" set and as a "background" copy.

At every frame start, the expected set is rebuilt from the background copy and narrowed to the enabled lines that actually carry a message. If the narrowed set is not empty, the block drops its active-low ready line for two clocks as an interrupt and places the message count in its status register. Each status-register read after that loads the next message into the data register and its line number into the status register. Lines are taken from the highest number down. A new frame start cuts off any unread messages and begins a fresh pass.

The host enables the function by reading the status register after a non-zero mask write, and only while no higher-priority short command is pending. A zero mask write or a reset switches the function off.

Top module: `chan_zero_extract`

## Requirements
- R1: A mask write with a non-zero mask {maskMsb, maskLsb} stores it as the background and expected sets and arms the function. In the next cycle, or2Data = {enabled-line count mod 8 in bits 7:5, 1 in bit 4, 1110 in bits 3:0}, so a full mask of 8 lines shows 000 in bits 7:5.
- R2: A mask write with an all-zero mask clears both sets and disarms and disables the function. In the next cycle or2Data is 0x0E, and later frames raise no interrupt until the function is armed and enabled again.
- R3: An armed function becomes enabled only through an or2 read taken while shortBusy is low. Frame starts before that produce no interrupt and change neither output register.
- R4: A line's channel-0 byte counts as a message exactly when its bits 7:6 differ from 01. All three other patterns (00, 10, 11) count.
- R5: On a frame start while enabled, the expected set becomes background AND message-lines. If this set is non-empty, dataReadyN is low in the two cycles that follow the frameStart edge and high in the third, and or2Data = {count mod 8, 1, 1110}. If it is empty, there is no pulse and both registers keep their values.
- R6: An or2 read during a pass loads, one cycle later, or1Data with the message of the highest line still pending. It also loads or2Data with {line number in bits 7:5, more-follow flag in bit 4, 1110}. The flag is 1 when further messages remain after this one.
- R7: An or2 read after the last message has been delivered, or outside a pass, changes neither register. An or1 read never changes any output.
- R8: A frame start during delivery abandons the remaining messages and starts a new pass from the background set with the new frame's bytes.
- R9: After reset, or1Data is 0x00, or2Data is 0x0E, dataReadyN is high and the function is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | One-cycle pulse marking a new frame; lineBytes valid with it |
| lineBytes | input | 64 | Channel-0 byte of each line, line i in bits 8i+7:8i |
| maskWrite | input | 1 | One-cycle mask store strobe |
| maskMsb | input | 3 | Mask bits 7:5 |
| maskLsb | input | 5 | Mask bits 4:0 |
| rdOr1 | input | 1 | Host read strobe of the data register |
| rdOr2 | input | 1 | Host read strobe of the status register |
| shortBusy | input | 1 | A higher-priority short command is still executing |
| dataReadyN | output | 1 | Active-low interrupt, low for two clocks per pass |
| or1Data | output | 8 | Data register: delivered message byte |
| or2Data | output | 8 | Status register: count or line number, flag, fixed tail 1110 |

## Verification
The bench builds the block with its default of eight lines, two-clock interrupt and 8-bit bytes. This width makes the full-mask case, in which a count of eight wraps to zero in a 3-bit field, directly reachable. The wide line set also leaves room for passes that skip filtered lines between messages. The two-clock pulse length lets the bench check the exact edges of the interrupt against the frame start.

// File: rtl/c0x_pkg.sv
package c0x_pkg;
  localparam logic [3:0] OR2_TAIL = 4'b1110;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_ANNOUNCE = 2'd1,
    ST_DELIVER  = 2'd2
  } c0State_t;

  typedef struct packed {
    logic maskLoad;
    logic maskClear;
    logic passLoad;
    logic passStep;
  } c0Strobe_t;
endpackage

// File: rtl/c0x_ctrl.sv
module c0x_ctrl
  import c0x_pkg::*;
#(
  parameter int PULSE_LEN = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      frameStart,
  input  logic      maskWrite,
  input  logic      maskNonZero,
  input  logic      rdOr2,
  input  logic      shortBusy,
  input  logic      passHasMsgs,
  input  logic      remainingAny,
  output c0Strobe_t strobe,
  output logic      dataReadyN
);
  localparam int PCNT_W = $clog2(PULSE_LEN + 1);

  c0State_t state, stateNext;
  logic armed, enabled;
  logic [PCNT_W-1:0] pulseCnt;

  always_comb begin
    strobe.maskLoad  = maskWrite && maskNonZero;
    strobe.maskClear = maskWrite && !maskNonZero;
    strobe.passLoad  = !maskWrite && frameStart && enabled;
    strobe.passStep  = !maskWrite && !frameStart && rdOr2 &&
                       ((state == ST_ANNOUNCE) || (state == ST_DELIVER && remainingAny));
  end

  always_comb begin
    stateNext = state;
    if (maskWrite)
      stateNext = ST_IDLE;
    else if (strobe.passLoad)
      stateNext = passHasMsgs ? ST_ANNOUNCE : ST_IDLE;
    else if (frameStart)
      stateNext = ST_IDLE;
    else if (strobe.passStep)
      stateNext = ST_DELIVER;
    else if (rdOr2 && state == ST_DELIVER)
      stateNext = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      armed    <= 1'b0;
      enabled  <= 1'b0;
      pulseCnt <= '0;
    end else begin
      state <= stateNext;
      if (strobe.maskClear) begin
        armed   <= 1'b0;
        enabled <= 1'b0;
      end else if (strobe.maskLoad) begin
        armed <= 1'b1;
      end else if (rdOr2 && armed && !shortBusy) begin
        enabled <= 1'b1;
      end
      if (strobe.passLoad && passHasMsgs)
        pulseCnt <= PCNT_W'(PULSE_LEN);
      else if (pulseCnt != '0)
        pulseCnt <= pulseCnt - 1'b1;
    end
  end

  assign dataReadyN = (pulseCnt == '0);
endmodule

// File: rtl/c0x_datapath.sv
module c0x_datapath
  import c0x_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int BYTE_W    = 8,
  parameter int LINE_W    = $clog2(NUM_LINES),
  parameter int OR2_W     = LINE_W + 5
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  c0Strobe_t                   strobe,
  input  logic [NUM_LINES-1:0]        maskIn,
  input  logic [NUM_LINES*BYTE_W-1:0] lineBytes,
  output logic                        passHasMsgs,
  output logic                        remainingAny,
  output logic [BYTE_W-1:0]           or1Data,
  output logic [OR2_W-1:0]            or2Data
);
  localparam int CNT_W = $clog2(NUM_LINES + 1);

  logic [NUM_LINES-1:0] bgMask, expMask, msgVec, reduced, afterTop;
  logic [BYTE_W-1:0]    msgLatch [NUM_LINES];
  logic [LINE_W-1:0]    topIdx;
  logic [CNT_W-1:0]     maskCnt, reducedCnt;

  function automatic logic [CNT_W-1:0] popCount(input logic [NUM_LINES-1:0] v);
    logic [CNT_W-1:0] c = '0;
    for (int i = 0; i < NUM_LINES; i++) c = c + CNT_W'(v[i]);
    return c;
  endfunction

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_sig
    assign msgVec[g] = lineBytes[g*BYTE_W+BYTE_W-1 -: 2] != 2'b01;
  end

  assign reduced      = bgMask & msgVec;
  assign passHasMsgs  = |reduced;
  assign remainingAny = |expMask;
  assign maskCnt      = popCount(maskIn);
  assign reducedCnt   = popCount(reduced);

  always_comb begin
    topIdx = '0;
    for (int i = 0; i < NUM_LINES; i++)
      if (expMask[i]) topIdx = LINE_W'(i);
    afterTop = expMask;
    afterTop[topIdx] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bgMask  <= '0;
      expMask <= '0;
      or1Data <= '0;
      or2Data <= {{(LINE_W+1){1'b0}}, OR2_TAIL};
      for (int i = 0; i < NUM_LINES; i++) msgLatch[i] <= '0;
    end else if (strobe.maskClear) begin
      bgMask  <= '0;
      expMask <= '0;
      or2Data <= {{(LINE_W+1){1'b0}}, OR2_TAIL};
    end else if (strobe.maskLoad) begin
      bgMask  <= maskIn;
      expMask <= maskIn;
      or2Data <= {maskCnt[LINE_W-1:0], 1'b1, OR2_TAIL};
    end else if (strobe.passLoad) begin
      expMask <= reduced;
      for (int i = 0; i < NUM_LINES; i++) msgLatch[i] <= lineBytes[i*BYTE_W +: BYTE_W];
      if (passHasMsgs) or2Data <= {reducedCnt[LINE_W-1:0], 1'b1, OR2_TAIL};
    end else if (strobe.passStep) begin
      expMask <= afterTop;
      or1Data <= msgLatch[topIdx];
      or2Data <= {topIdx, |afterTop, OR2_TAIL};
    end
  end
endmodule

// File: rtl/chan_zero_extract.sv
module chan_zero_extract
  import c0x_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int BYTE_W    = 8,
  parameter int PULSE_LEN = 2,
  parameter int LINE_W    = $clog2(NUM_LINES),
  parameter int OR2_W     = LINE_W + 5
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        frameStart,
  input  logic [NUM_LINES*BYTE_W-1:0] lineBytes,
  input  logic                        maskWrite,
  input  logic [2:0]                  maskMsb,
  input  logic [NUM_LINES-4:0]        maskLsb,
  input  logic                        rdOr1,
  input  logic                        rdOr2,
  input  logic                        shortBusy,
  output logic                        dataReadyN,
  output logic [BYTE_W-1:0]           or1Data,
  output logic [OR2_W-1:0]            or2Data
);
  c0Strobe_t strobe;
  logic [NUM_LINES-1:0] maskIn;
  logic passHasMsgs, remainingAny, unusedRd;

  assign maskIn   = {maskMsb, maskLsb};
  assign unusedRd = rdOr1;

  c0x_ctrl #(.PULSE_LEN(PULSE_LEN)) i_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .maskWrite(maskWrite),
    .maskNonZero(|maskIn), .rdOr2(rdOr2), .shortBusy(shortBusy),
    .passHasMsgs(passHasMsgs), .remainingAny(remainingAny),
    .strobe(strobe), .dataReadyN(dataReadyN)
  );

  c0x_datapath #(.NUM_LINES(NUM_LINES), .BYTE_W(BYTE_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .maskIn(maskIn),
    .lineBytes(lineBytes), .passHasMsgs(passHasMsgs), .remainingAny(remainingAny),
    .or1Data(or1Data), .or2Data(or2Data)
  );
endmodule

// File: rtl/c0x_checker.sv
module c0x_checker #(
  parameter int BYTE_W = 8,
  parameter int OR2_W  = 8,
  parameter int MASK_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameStart,
  input logic              maskWrite,
  input logic [MASK_W-1:0] maskIn,
  input logic              rdOr2,
  input logic              dataReadyN,
  input logic [BYTE_W-1:0] or1Data,
  input logic [OR2_W-1:0]  or2Data
);
  AST_DR_FROM_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dataReadyN) |-> $past(frameStart)); // R5
  AST_DR_TWO_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dataReadyN) |=> !dataReadyN); // R5
  AST_OR1_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    !rdOr2 |=> $stable(or1Data)); // R7
  AST_ZERO_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (maskWrite && maskIn == '0) |=> or2Data == OR2_W'(8'h0E)); // R2
  AST_OR2_TAIL: assert property (@(posedge clk) disable iff (!rstN)
    or2Data[3:0] == 4'b1110); // R6
endmodule

bind chan_zero_extract c0x_checker #(.BYTE_W(BYTE_W), .OR2_W(OR2_W), .MASK_W(NUM_LINES)) i_chk (
  .clk(clk), .rstN(rstN), .frameStart(frameStart), .maskWrite(maskWrite),
  .maskIn({maskMsb, maskLsb}), .rdOr2(rdOr2), .dataReadyN(dataReadyN),
  .or1Data(or1Data), .or2Data(or2Data)
);

// File: tb/test_chan_zero_extract.sv
module test_chan_zero_extract;
  logic clk = 0, rstN = 0, frameStart = 0, maskWrite = 0, rdOr1 = 0, rdOr2 = 0, shortBusy = 0;
  logic [63:0] lineBytes = '0;
  logic [2:0] maskMsb = '0;
  logic [4:0] maskLsb = '0;
  logic dataReadyN;
  logic [7:0] or1Data, or2Data;
  int nChecks = 0, nFail = 0;

  // reference model state
  logic [7:0] bgM = 0, expM = 0, or1M = 0, or2M = 8'h0E;
  logic [63:0] latchM = 0;
  logic armedM = 0, enM = 0;
  int stM = 0;

  always #2 clk = ~clk;

  chan_zero_extract i_chan_zero_extract (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .lineBytes(lineBytes),
    .maskWrite(maskWrite), .maskMsb(maskMsb), .maskLsb(maskLsb), .rdOr1(rdOr1),
    .rdOr2(rdOr2), .shortBusy(shortBusy), .dataReadyN(dataReadyN),
    .or1Data(or1Data), .or2Data(or2Data));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] msgLines(input logic [63:0] b);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = (b[i*8+6 +: 2] != 2'b01);
    return v;
  endfunction

  function automatic int pop(input logic [7:0] v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += v[i];
    return c;
  endfunction

  task automatic doMask(input logic [7:0] m);
    @(negedge clk);
    maskWrite = 1; {maskMsb, maskLsb} = m;
    @(negedge clk);
    maskWrite = 0;
    stM = 0;
    if (m != 0) begin
      bgM = m; expM = m; armedM = 1;
      or2M = {3'(pop(m)), 1'b1, 4'b1110};
    end else begin
      bgM = 0; expM = 0; armedM = 0; enM = 0; or2M = 8'h0E;
    end
    check(m == 0 ? "R2 or2 after zero mask" : "R1 or2 after mask", or2Data, or2M);
  endtask

  task automatic doFrame(input logic [63:0] b, input string req);
    logic pulse = 0;
    @(negedge clk);
    frameStart = 1; lineBytes = b;
    @(negedge clk);
    frameStart = 0;
    if (enM) begin
      expM = bgM & msgLines(b); latchM = b;
      if (expM != 0) begin
        pulse = 1; stM = 1;
        or2M = {3'(pop(expM)), 1'b1, 4'b1110};
      end else stM = 0;
    end else stM = 0;
    check({req, " dr low cycle 1"}, dataReadyN, !pulse);
    check({req, " or2 after frame"}, or2Data, or2M);
    check({req, " or1 after frame"}, or1Data, or1M);
    @(negedge clk);
    check({req, " dr low cycle 2"}, dataReadyN, !pulse);
    @(negedge clk);
    check("R5 dr high cycle 3", dataReadyN, 1'b1);
  endtask

  task automatic doRd2(input string req);
    int top;
    @(negedge clk);
    rdOr2 = 1;
    @(negedge clk);
    rdOr2 = 0;
    if (stM == 1 || (stM == 2 && expM != 0)) begin
      top = 0;
      for (int i = 0; i < 8; i++) if (expM[i]) top = i;
      expM[top] = 0;
      or1M = latchM[top*8 +: 8];
      or2M = {3'(top), expM != 0, 4'b1110};
      stM = 2;
    end else if (stM == 2) stM = 0;
    if (armedM && !shortBusy) enM = 1;
    check({req, " or1"}, or1Data, or1M);
    check({req, " or2"}, or2Data, or2M);
    repeat (5) @(negedge clk);
  endtask

  task automatic doRd1();
    @(negedge clk);
    rdOr1 = 1;
    @(negedge clk);
    rdOr1 = 0;
    check("R7 or1 read leaves or1", or1Data, or1M);
    check("R7 or1 read leaves or2", or2Data, or2M);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  initial begin
    #(4 * 150000);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] b;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R9 reset or1", or1Data, 8'h00);
    check("R9 reset or2", or2Data, 8'h0E);
    check("R9 reset dr", dataReadyN, 1'b1);
    doFrame(64'h0, "R9 disabled after reset");

    // full mask, not yet enabled; count of 8 wraps to 000
    shortBusy = 1;
    doMask(8'hFF);
    check("R1 full mask count field", or2Data[7:5], 3'b000);
    doFrame(64'hC0_80_00_3F_FF_9A_4B_21, "R3 armed not enabled");
    doRd2("R3 or2 read while busy");
    doFrame(64'hC0_80_00_3F_FF_9A_4B_21, "R3 still disabled");
    shortBusy = 0;
    doRd2("R3 enabling read");
    // all eight lines carry non-01 patterns (00,10,11)
    doFrame(64'hC0_80_00_3F_FF_9A_BB_21, "R5 full pass");
    for (int k = 0; k < 8; k++) doRd2("R6 descending step");
    doRd2("R7 read after last");
    doRd1();

    // filtered lines and cut-off
    doMask(8'h5A);
    doFrame(64'h11_42_7F_95_40_E0_55_02, "R4 filter 01");
    doRd2("R6 first step");
    doFrame(64'h11_C2_7F_95_00_E0_55_02, "R8 restart");
    doRd2("R8 step after restart");
    doRd2("R8 second step");
    doFrame(64'h41_42_43_44_45_46_47_48, "R5 no messages");
    doRd2("R7 read outside pass");

    // random frames
    for (int f = 0; f < 40; f++) begin
      if (f % 7 == 3) doMask(8'($urandom_range(1, 255)));
      b = {$urandom, $urandom};
      doFrame(b, "R5 random frame");
      for (int k = 0; k < $urandom_range(0, 9); k++) doRd2("R6 random step");
      if (f % 5 == 0) doRd1();
    end

    // zero mask disables; re-arming needs a read
    doMask(8'h00);
    doFrame(64'h0, "R2 after zero mask");
    doMask(8'h81);
    doFrame(64'h0, "R2 rearmed not enabled");
    doRd2("R3 enable again");
    doFrame(64'h80_00_00_00_00_00_00_C3, "R5 two lines");
    doRd2("R6 line7");
    doRd2("R6 line0");

    summary();
    $finish;
  end
endmodule